// File: doc/BRIEF.md
# I2C Master Target-Address Register Slice

This block holds the target address and addressing mode that an I2C master uses. It sits behind a simple register write port. Each field of the address register has its own rule for when software may change it. The rules depend on three things: whether the controller is enabled, whether the master is idle with an empty transmit FIFO, and a build-time option that allows the address to be changed while the controller runs.

A second register offset is the command path. Writing there pushes one entry into the transmit command FIFO. An entry carries either a data byte to send or a read request. Write and read entries can follow each other in any order. The bus protocol engine and the FIFO storage sit outside this block.

The register layout is fixed because the protocol engine decodes it:
- bits 9:0 hold the target address;
- bits 11:10 hold a two-bit special-mode field;
- bit 12 selects the addressing width (0 = 7-bit, 1 = 10-bit).

Top module: `i2c_tgt_addr_regs`

## Requirements
- R1: While reset is high and after it is released, the outputs take their reset values: `tgt_addr` equals parameter `TGT_RST`, `addr10_mode` is 0, `spec_mode` is 0 and `push_valid` is 0.
- R2: While `ctrl_en` is 0, an address-register write (`wr_addr` == `TAR_OFS`) updates all three fields, whatever the value of `DYN_UPDATE`. The fields are bits 9:0 (address), bits 11:10 (special mode) and bit 12 (addressing width).
- R3: While `ctrl_en` is 1, writes to `spec_mode` (bits 11:10) are ignored.
- R4: While `ctrl_en` is 1 and `DYN_UPDATE` is 1, the address bits 9:0 and bit 12 are updated only when `mst_idle` is 1 and `txf_empty` is 1; otherwise that part of the write is ignored.
- R5: While `ctrl_en` is 1 and `DYN_UPDATE` is 0, writes to the address bits 9:0 and bit 12 are ignored.
- R6: Byte strobe bit 0 gates register bits 7:0, and strobe bit 1 gates register bits 12:8. Bits whose lane strobe is 0 keep their value.
- R7: A command write (`wr_addr` == `CMD_OFS`, both strobes set) with bit 8 equal to 0 produces `push_valid` in the next cycle. The pushed entry has `push_rd` = 0 and `push_byte` = data bits 7:0.
- R8: A command write with bit 8 equal to 1 produces a push with `push_rd` = 1 and `push_byte` = 0; the low data byte is ignored.
- R9: A push lasts one cycle per accepted command write. No push follows a command write made while `txf_full` is 1, or a command write that lacks either strobe.
- R10: A write to any other offset, or a cycle with `wr_en` low, changes no register field and causes no push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write request |
| wr_addr | input | ADDR_W | Register word offset |
| wr_data | input | 13 | Write data (register bits 12:0) |
| wr_strb | input | 2 | Lane strobes: bit 0 for bits 7:0, bit 1 for bits 12:8 |
| ctrl_en | input | 1 | Controller enabled |
| mst_idle | input | 1 | Master bus activity is idle |
| txf_empty | input | 1 | Transmit FIFO is empty |
| txf_full | input | 1 | Transmit FIFO is full |
| tgt_addr | output | 10 | Current target address |
| addr10_mode | output | 1 | 1 = 10-bit addressing |
| spec_mode | output | 2 | Special-mode field |
| push_valid | output | 1 | One-cycle FIFO push strobe |
| push_rd | output | 1 | Pushed entry is a read request |
| push_byte | output | 8 | Pushed data byte (0 for reads) |

## Verification
The bench targets the points where the permission rules meet:
- **Enabled but not idle.** Writes arrive while the controller is enabled and only one of `mst_idle` and `txf_empty` is high. A design that checked only one of the two flags would change the address while a transfer is still draining.
- **Field split on an enabled write.** A single write touches the special field and the address together. A design that gated the whole register with one enable would either lose the allowed address update or let `spec_mode` change.
- **Build option off.** A second instance is built with the dynamic-update option off. This exposes any design that ignores the option.
- **Command corner cases.** The bench sends read commands with non-zero low bytes, command writes while the FIFO is full, and command writes with a missing strobe. A design that got these wrong would push stale bytes, overflow the FIFO or push on partial writes.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int TGT_W   = 10;
    localparam int SPEC_W  = 2;
    localparam int BYTE_W  = 8;
    localparam int REG_W   = TGT_W + SPEC_W + 1;
    localparam int LANES   = 2;
    localparam int CMD_BIT = 8;

    // Bit order matches the register layout: 12 width select, 11:10 special, 9:0 address
    typedef struct packed {
        logic              addr10;
        logic [SPEC_W-1:0] spec;
        logic [TGT_W-1:0]  tgt;
    } tar_reg_t;

    typedef struct packed {
        logic              rd;
        logic [BYTE_W-1:0] dat;
    } cmd_t;

    typedef struct packed {
        logic spec_ok;
        logic addr_ok;
    } wperm_t;

    // Per-bit write mask from lane strobes
    function automatic logic [REG_W-1:0] lane_mask(input logic [LANES-1:0] strb);
        return {{(REG_W-BYTE_W){strb[1]}}, {BYTE_W{strb[0]}}};
    endfunction

    // Per-bit write mask from field permissions
    function automatic logic [REG_W-1:0] field_mask(input wperm_t p);
        return {p.addr_ok, {SPEC_W{p.spec_ok}}, {TGT_W{p.addr_ok}}};
    endfunction

endpackage

// File: rtl/i2c_tgt_wr_decode.sv
module i2c_tgt_wr_decode
    import i2c_tgt_pkg::*;
#(
    parameter int          ADDR_W     = 4,
    parameter logic [ADDR_W-1:0] TAR_OFS = 4'h1,
    parameter logic [ADDR_W-1:0] CMD_OFS = 4'h4,
    parameter bit          DYN_UPDATE = 1'b1
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_strb,
    input  logic              ctrl_en,
    input  logic              mst_idle,
    input  logic              txf_empty,
    output logic              tar_wr,
    output logic              cmd_wr,
    output wperm_t            perm
);

    logic dyn_ok;

    generate
        if (DYN_UPDATE) begin : g_dyn
            assign dyn_ok = mst_idle & txf_empty;
        end else begin : g_static
            logic unused_flags;
            assign unused_flags = mst_idle ^ txf_empty;
            assign dyn_ok = 1'b0;
        end
    endgenerate

    always_comb begin
        tar_wr       = wr_en && (wr_addr == TAR_OFS);
        cmd_wr       = wr_en && (wr_addr == CMD_OFS) && (&wr_strb);
        perm.spec_ok = !ctrl_en;
        perm.addr_ok = !ctrl_en || dyn_ok;
    end

endmodule

// File: rtl/i2c_tgt_addr_store.sv
module i2c_tgt_addr_store
    import i2c_tgt_pkg::*;
#(
    parameter logic [TGT_W-1:0] TGT_RST = 10'h055
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tar_wr,
    input  wperm_t           perm,
    input  logic [LANES-1:0] wr_strb,
    input  logic [REG_W-1:0] wr_data,
    output tar_reg_t         q
);

    localparam tar_reg_t RST_VAL = '{addr10: 1'b0, spec: '0, tgt: TGT_RST};

    logic [REG_W-1:0] we_bits;
    logic [REG_W-1:0] rst_bits;
    logic [REG_W-1:0] q_bits;

    assign we_bits  = {REG_W{tar_wr}} & lane_mask(wr_strb) & field_mask(perm);
    assign rst_bits = RST_VAL;

    genvar b;
    generate
        for (b = 0; b < REG_W; b++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)
                    q_bits[b] <= rst_bits[b];
                else if (we_bits[b])
                    q_bits[b] <= wr_data[b];
            end
        end
    endgenerate

    assign q = q_bits;

endmodule

// File: rtl/i2c_tgt_cmd_push.sv
module i2c_tgt_cmd_push
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic              txf_full,
    input  logic [CMD_BIT:0]  wr_cmd,
    output logic              push_valid,
    output cmd_t              push_q
);

    cmd_t next_cmd;

    always_comb begin
        next_cmd.rd  = wr_cmd[CMD_BIT];
        next_cmd.dat = wr_cmd[CMD_BIT] ? '0 : wr_cmd[BYTE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            push_valid <= 1'b0;
            push_q     <= '0;
        end else begin
            push_valid <= cmd_wr && !txf_full;
            if (cmd_wr && !txf_full)
                push_q <= next_cmd;
        end
    end

endmodule

// File: rtl/i2c_tgt_addr_regs.sv
module i2c_tgt_addr_regs
    import i2c_tgt_pkg::*;
#(
    parameter int                ADDR_W     = 4,
    parameter logic [ADDR_W-1:0] TAR_OFS    = 4'h1,
    parameter logic [ADDR_W-1:0] CMD_OFS    = 4'h4,
    parameter bit                DYN_UPDATE = 1'b1,
    parameter logic [9:0]        TGT_RST    = 10'h055
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [12:0]       wr_data,
    input  logic [1:0]        wr_strb,
    input  logic              ctrl_en,
    input  logic              mst_idle,
    input  logic              txf_empty,
    input  logic              txf_full,
    output logic [9:0]        tgt_addr,
    output logic              addr10_mode,
    output logic [1:0]        spec_mode,
    output logic              push_valid,
    output logic              push_rd,
    output logic [7:0]        push_byte
);

    logic     tar_wr;
    logic     cmd_wr;
    wperm_t   perm;
    tar_reg_t tar_q;
    cmd_t     push_q;

    i2c_tgt_wr_decode #(
        .ADDR_W(ADDR_W), .TAR_OFS(TAR_OFS), .CMD_OFS(CMD_OFS), .DYN_UPDATE(DYN_UPDATE)
    ) dec_i (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_strb(wr_strb), .ctrl_en(ctrl_en),
        .mst_idle(mst_idle), .txf_empty(txf_empty),
        .tar_wr(tar_wr), .cmd_wr(cmd_wr), .perm(perm)
    );

    i2c_tgt_addr_store #(.TGT_RST(TGT_RST)) store_i (
        .clk(clk), .rst(rst), .tar_wr(tar_wr), .perm(perm),
        .wr_strb(wr_strb), .wr_data(wr_data), .q(tar_q)
    );

    i2c_tgt_cmd_push push_i (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .txf_full(txf_full),
        .wr_cmd(wr_data[CMD_BIT:0]), .push_valid(push_valid), .push_q(push_q)
    );

    logic unused_hi;
    assign unused_hi = ^wr_data[12:9];

    assign tgt_addr    = tar_q.tgt;
    assign addr10_mode = tar_q.addr10;
    assign spec_mode   = tar_q.spec;
    assign push_rd     = push_q.rd;
    assign push_byte   = push_q.dat;

endmodule

// File: rtl/i2c_tgt_addr_regs_chk.sv
module i2c_tgt_addr_regs_chk #(
    parameter int                ADDR_W     = 4,
    parameter logic [ADDR_W-1:0] TAR_OFS    = 4'h1,
    parameter logic [ADDR_W-1:0] CMD_OFS    = 4'h4,
    parameter bit                DYN_UPDATE = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              ctrl_en,
    input logic              mst_idle,
    input logic              txf_empty,
    input logic              txf_full,
    input logic [9:0]        tgt_addr,
    input logic              addr10_mode,
    input logic [1:0]        spec_mode,
    input logic              push_valid,
    input logic              push_rd,
    input logic [7:0]        push_byte
);

    logic dyn_allowed;
    assign dyn_allowed = DYN_UPDATE && mst_idle && txf_empty;

    assert_spec_locked_R3: assert property (@(posedge clk) disable iff (rst)
        ctrl_en |=> $stable(spec_mode));

    assert_addr_locked_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_en && !dyn_allowed) |=> ($stable(tgt_addr) && $stable(addr10_mode)));

    assert_rd_byte_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (push_valid && push_rd) |-> (push_byte == 8'h00));

    assert_no_push_full_R9: assert property (@(posedge clk) disable iff (rst)
        txf_full |=> !push_valid);

    assert_push_needs_cmd_R9: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == CMD_OFS) |=> !push_valid);

    assert_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || (wr_addr != TAR_OFS && wr_addr != CMD_OFS)) |=>
        ($stable(tgt_addr) && $stable(spec_mode) && $stable(addr10_mode) && !push_valid));

endmodule

bind i2c_tgt_addr_regs i2c_tgt_addr_regs_chk #(
    .ADDR_W(ADDR_W), .TAR_OFS(TAR_OFS), .CMD_OFS(CMD_OFS), .DYN_UPDATE(DYN_UPDATE)
) chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .ctrl_en(ctrl_en),
    .mst_idle(mst_idle), .txf_empty(txf_empty), .txf_full(txf_full),
    .tgt_addr(tgt_addr), .addr10_mode(addr10_mode), .spec_mode(spec_mode),
    .push_valid(push_valid), .push_rd(push_rd), .push_byte(push_byte)
);

// File: tb/i2c_tgt_addr_regs_tb_top.sv
module i2c_tgt_addr_regs_tb_top;

    localparam logic [3:0] TAR = 4'h1;
    localparam logic [3:0] CMD = 4'h4;
    localparam logic [9:0] RSTA = 10'h055;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [12:0] wr_data;
    logic [1:0]  wr_strb;
    logic        ctrl_en, mst_idle, txf_empty, txf_full;

    logic [9:0] ta_a, ta_b;
    logic       m10_a, m10_b;
    logic [1:0] sp_a, sp_b;
    logic       pv_a, pv_b, pr_a, pr_b;
    logic [7:0] pb_a, pb_b;

    int checks = 0;
    int fails  = 0;
    logic [12:0] mdl_dyn, mdl_st;

    always #2 clk = ~clk;

    i2c_tgt_addr_regs #(.DYN_UPDATE(1'b1)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_strb(wr_strb), .ctrl_en(ctrl_en), .mst_idle(mst_idle), .txf_empty(txf_empty),
        .txf_full(txf_full), .tgt_addr(ta_a), .addr10_mode(m10_a), .spec_mode(sp_a),
        .push_valid(pv_a), .push_rd(pr_a), .push_byte(pb_a));

    i2c_tgt_addr_regs #(.DYN_UPDATE(1'b0)) dut_st_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_strb(wr_strb), .ctrl_en(ctrl_en), .mst_idle(mst_idle), .txf_empty(txf_empty),
        .txf_full(txf_full), .tgt_addr(ta_b), .addr10_mode(m10_b), .spec_mode(sp_b),
        .push_valid(pv_b), .push_rd(pr_b), .push_byte(pb_b));

    // Expected register value: {bit12 width, 11:10 special, 9:0 address}
    function automatic logic [12:0] next_reg(input logic [12:0] cur, input bit dyn,
            input logic we, input logic [3:0] a, input logic [12:0] d, input logic [1:0] s,
            input logic en, input logic idle, input logic empty);
        logic addr_ok, spec_ok;
        logic [12:0] m, r;
        addr_ok = !en || (dyn && idle && empty);
        spec_ok = !en;
        m = {{5{s[1]}}, {8{s[0]}}} & {addr_ok, spec_ok, spec_ok, {10{addr_ok}}};
        r = cur;
        if (we && a == TAR) r = (cur & ~m) | (d & m);
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cyc(input string req, input logic we, input logic [3:0] a,
            input logic [12:0] d, input logic [1:0] s, input logic en,
            input logic idle, input logic empty, input logic full);
        logic exp_pv;
        logic [8:0] exp_cmd;
        wr_en = we; wr_addr = a; wr_data = d; wr_strb = s;
        ctrl_en = en; mst_idle = idle; txf_empty = empty; txf_full = full;
        mdl_dyn = next_reg(mdl_dyn, 1'b1, we, a, d, s, en, idle, empty);
        mdl_st  = next_reg(mdl_st,  1'b0, we, a, d, s, en, idle, empty);
        exp_pv  = we && a == CMD && s == 2'b11 && !full;
        exp_cmd = d[8] ? 9'h100 : {1'b0, d[7:0]};
        @(posedge clk);
        @(negedge clk);
        check(req, {19'd0, m10_a, sp_a, ta_a}, {19'd0, mdl_dyn});
        check(req, {19'd0, m10_b, sp_b, ta_b}, {19'd0, mdl_st});
        check(req, {31'd0, pv_a}, {31'd0, exp_pv});
        check(req, {31'd0, pv_b}, {31'd0, exp_pv});
        if (exp_pv) begin
            check(req, {23'd0, pr_a, pb_a}, {23'd0, exp_cmd});
            check(req, {23'd0, pr_b, pb_b}, {23'd0, exp_cmd});
        end
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        string tg;
        seed = $urandom(32'h1C2A);
        rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0; wr_strb = 0;
        ctrl_en = 0; mst_idle = 1; txf_empty = 1; txf_full = 0;
        mdl_dyn = {3'b000, RSTA}; mdl_st = {3'b000, RSTA};
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1", {19'd0, m10_a, sp_a, ta_a}, {19'd0, 3'b000, RSTA});
        check("R1", {31'd0, pv_a}, 32'd0);
        rst = 1'b0;
        cyc("R1 R10", 0, TAR, 13'h1FFF, 2'b11, 0, 1, 1, 0);
        // R2 disabled: all fields writable on both builds
        cyc("R2", 1, TAR, 13'h1EAB, 2'b11, 0, 0, 0, 0);
        cyc("R2", 1, TAR, 13'h0412, 2'b11, 0, 1, 0, 1);
        // R6 single lanes
        cyc("R6", 1, TAR, 13'h1FFF, 2'b01, 0, 1, 1, 0);
        cyc("R6", 1, TAR, 13'h1A00, 2'b10, 0, 1, 1, 0);
        // R3 special field locked while enabled, even when idle
        cyc("R3 R4", 1, TAR, 13'h0C33, 2'b11, 1, 1, 1, 0);
        // R4 busy or FIFO non-empty blocks address update
        cyc("R4", 1, TAR, 13'h13C1, 2'b11, 1, 0, 1, 0);
        cyc("R4", 1, TAR, 13'h13C2, 2'b11, 1, 1, 0, 0);
        // R5 static build ignores enabled writes
        cyc("R5", 1, TAR, 13'h1155, 2'b11, 1, 1, 1, 0);
        // R7 write command, R8 read command with non-zero byte
        cyc("R7", 1, CMD, 13'h00A5, 2'b11, 1, 0, 0, 0);
        cyc("R8", 1, CMD, 13'h01FF, 2'b11, 1, 0, 0, 0);
        cyc("R7", 1, CMD, 13'h003C, 2'b11, 1, 0, 0, 0);
        // R9 full FIFO, missing strobe, single pulse
        cyc("R9", 1, CMD, 13'h0077, 2'b11, 1, 0, 0, 1);
        cyc("R9", 1, CMD, 13'h0077, 2'b01, 1, 0, 0, 0);
        cyc("R9", 0, CMD, 13'h0077, 2'b11, 1, 0, 0, 0);
        // R10 other offset
        cyc("R10", 1, 4'h7, 13'h1FFF, 2'b11, 0, 1, 1, 0);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] a;
            logic [31:0] r;
            r = $urandom;
            case (r[1:0])
                2'd0: a = TAR;
                2'd1: a = CMD;
                2'd2: a = TAR;
                default: a = 4'(r[31:28]);
            endcase
            if (a == TAR && !r[4])      tg = "R2 R6";
            else if (a == TAR)          tg = "R3 R4 R5 R6";
            else if (a == CMD)          tg = "R7 R8 R9";
            else                        tg = "R10";
            cyc(tg, r[2] | r[3], a, 13'($urandom), r[9:8] | {1'b0, r[10]},
                r[4], r[5], r[6], r[7] & r[11]);
        end
        cyc("R10", 0, TAR, 13'h0, 2'b00, 0, 1, 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule